// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block holds the control-side registers of a four-channel DMA engine and decides which channel is next in line for service. A host writes single bytes to eight control offsets. They cover the global command byte, software requests, per-channel and whole-register masking, per-channel mode bytes, a byte-pointer clear and a master reset. The host can read back two values: the status byte, which holds request and terminal-count flags, and the mask. Peripherals can raise or drop a channel request through hold and release pulses. The transfer datapath reports the end of a block on a terminal-count input.

Once per clock the block looks at the unmasked channels that have a pending request and grants the lowest-numbered one. It presents that channel's number and decoded mode fields to the transfer engine. Address and count registers, and the bus cycles that move the data, belong to the neighbouring datapath. That datapath also receives the byte-pointer clear pulse from this block.

Top module: `dmactl_top`

## Requirements
- R1: The register index is bits [3:0] of `portAddr >> WIDTH_SHIFT`. Address bits below WIDTH_SHIFT do not affect decoding. Writes whose index is 8 to 15 change no state.
- R2: A command write (index 0) is stored only when no bit other than bit 2 is set. Any other value is discarded and the previous command is kept.
- R3: A request write (index 1) selects channel `data[1:0]`. It sets that channel's request flag (status bit ch+4) when `data[2]` is 1 and clears it when `data[2]` is 0. It also clears that channel's terminal-count flag (status bit ch).
- R4: A single-mask write (index 2) sets the mask bit of channel `data[1:0]` when `data[2]` is 1 and clears it otherwise.
- R5: A mode write (index 3) updates the mode of channel `data[1:0]`. The transfer type comes from bits [3:2], auto-initialize from bit 4, address decrement from bit 5 and operating mode from bits [7:6]. All four are output for the granted channel.
- R6: A write to index 4 or to index 5 makes `ptrClear` high for exactly the one cycle after the write edge.
- R7: Master reset (a write to index 5) sets all mask bits, clears all status flags and clears the command, and leaves the mode registers unchanged. Hardware reset gives the same state and also zeroes the modes.
- R8: A write to index 6 clears every mask bit. A write to index 7 loads the mask bits from `data[3:0]`.
- R9: Reading index 0 returns `{request[3:0], tc[3:0]}` and clears the tc flags at the clock edge. A tc input pulse in the same cycle still sets its flag.
- R10: Reading index 1 returns `{4'b0, mask[3:0]}`. Reads of any other index return 0.
- R11: A channel is eligible when its mask bit is 0 and its request flag is 1. On each clock edge the grant registers the lowest-numbered eligible channel with its mode fields. When no channel is eligible, all grant outputs are 0.
- R12: While command bit 2 (controller disable) is 1, no grant is given.
- R13: A `dreqHold` pulse sets a channel's request flag and a `dreqRelease` pulse clears it. If both arrive together, release wins. A software request or master-reset write in the same cycle overrides both.
- R14: A `tcHit` pulse sets the channel's terminal-count flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| rdEn | input | 1 | Byte read strobe |
| portAddr | input | ADDR_W | Control port address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from address and state |
| dreqHold | input | 4 | Per-channel request raise pulses |
| dreqRelease | input | 4 | Per-channel request drop pulses |
| tcHit | input | 4 | Per-channel terminal-count pulses from the datapath |
| grantValid | output | 1 | A channel is granted |
| grantCh | output | 2 | Granted channel number |
| grantXferType | output | 2 | Transfer type of granted channel |
| grantAutoInit | output | 1 | Auto-initialize flag of granted channel |
| grantDecrement | output | 1 | Address-decrement flag of granted channel |
| grantOpMode | output | 2 | Operating mode of granted channel |
| ptrClear | output | 1 | One-cycle byte-pointer clear pulse |

## Verification
The bench builds the block with WIDTH_SHIFT=1 and ADDR_W=8, which is the word-wide controller arrangement. This makes the odd addresses aliases of the even ones and puts indices 8 to 15 at addresses 0x10 to 0x1F, so both the shift and the ignored-index paths are exercised. A behavioural model updates once per edge and is compared with the grant outputs and `ptrClear` on every clock. The stimulus covers competing requests, masking, the disable bit, rejected command values and collisions between pulses and reads.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
  localparam int NUM_CH   = 4;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = 4;
  localparam int MODE_W   = 6;
  localparam int SEL_BIT  = 2;
  localparam int DIS_BIT  = 2;
  localparam logic [BYTE_W-1:0] CMD_KEEP = 8'h04;

  typedef enum logic [IDX_W-1:0] {
    IX_COMMAND  = 4'd0,
    IX_REQUEST  = 4'd1,
    IX_MASKONE  = 4'd2,
    IX_MODE     = 4'd3,
    IX_PTRCLR   = 4'd4,
    IX_MRESET   = 4'd5,
    IX_MASKCLR  = 4'd6,
    IX_MASKLOAD = 4'd7
  } ctlIdx_e;

  typedef struct packed {
    logic [1:0] opMode;
    logic       decrement;
    logic       autoInit;
    logic [1:0] xferType;
  } modeFields_t;

  typedef struct packed {
    logic              cmdWr;
    logic              reqWr;
    logic              maskOneWr;
    logic              modeWr;
    logic              ptrClr;
    logic              masterRst;
    logic              maskClrAll;
    logic              maskLoad;
    logic              statusRd;
    logic              maskRd;
    logic [CH_W-1:0]   chSel;
    logic [BYTE_W-1:0] data;
  } ctlStrobe_t;
endpackage

// File: rtl/dmactl_decode.sv
module dmactl_decode
  import dmactl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int WIDTH_SHIFT = 0
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic [BYTE_W-1:0] wrData,
  output ctlStrobe_t        strb
);
  localparam int USED_HI = WIDTH_SHIFT + IDX_W;

  logic [IDX_W-1:0] regIdx;
  logic             cmdAcceptable;

  assign regIdx = portAddr[USED_HI-1:WIDTH_SHIFT];

  generate
    if (WIDTH_SHIFT > 0) begin : g_lowBits
      logic unusedLow;
      assign unusedLow = ^portAddr[WIDTH_SHIFT-1:0];
    end
    if (ADDR_W > USED_HI) begin : g_highBits
      logic unusedHigh;
      assign unusedHigh = ^portAddr[ADDR_W-1:USED_HI];
    end
  endgenerate

  assign cmdAcceptable = ((wrData & ~CMD_KEEP) == '0);

  always_comb begin
    strb       = '0;
    strb.chSel = wrData[CH_W-1:0];
    strb.data  = wrData;
    if (wrEn) begin
      unique case (regIdx)
        IX_COMMAND:  strb.cmdWr      = cmdAcceptable;
        IX_REQUEST:  strb.reqWr      = 1'b1;
        IX_MASKONE:  strb.maskOneWr  = 1'b1;
        IX_MODE:     strb.modeWr     = 1'b1;
        IX_PTRCLR:   strb.ptrClr     = 1'b1;
        IX_MRESET:   strb.masterRst  = 1'b1;
        IX_MASKCLR:  strb.maskClrAll = 1'b1;
        IX_MASKLOAD: strb.maskLoad   = 1'b1;
        default: ;
      endcase
    end
    if (rdEn) begin
      strb.statusRd = (regIdx == IX_COMMAND);
      strb.maskRd   = (regIdx == IX_REQUEST);
    end
  end
endmodule

// File: rtl/dmactl_regs.sv
module dmactl_regs
  import dmactl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strb,
  input  logic [NUM_CH-1:0] dreqHold,
  input  logic [NUM_CH-1:0] dreqRelease,
  input  logic [NUM_CH-1:0] tcHit,
  output logic [BYTE_W-1:0] rdData,
  output logic [NUM_CH-1:0] eligVec,
  output logic              ctlDisable,
  output modeFields_t       chMode [NUM_CH],
  output logic              ptrClrPulse
);
  logic [BYTE_W-1:0] cmdReg, cmdNext;
  logic [NUM_CH-1:0] maskReg, maskNext;
  logic [NUM_CH-1:0] reqBits, reqNext;
  logic [NUM_CH-1:0] tcBits, tcNext;
  logic              selBit;

  assign selBit = strb.data[SEL_BIT];

  always_comb begin
    cmdNext  = cmdReg;
    maskNext = maskReg;
    reqNext  = reqBits;
    tcNext   = tcBits;
    if (strb.statusRd) tcNext = '0;
    tcNext  = tcNext | tcHit;
    reqNext = (reqNext | dreqHold) & ~dreqRelease;
    if (strb.cmdWr) cmdNext = strb.data;
    if (strb.reqWr) begin
      reqNext[strb.chSel] = selBit;
      tcNext[strb.chSel]  = 1'b0;
    end
    if (strb.maskOneWr)  maskNext[strb.chSel] = selBit;
    if (strb.maskClrAll) maskNext = '0;
    if (strb.maskLoad)   maskNext = strb.data[NUM_CH-1:0];
    if (strb.masterRst) begin
      maskNext = '1;
      reqNext  = '0;
      tcNext   = '0;
      cmdNext  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg      <= '0;
      maskReg     <= '1;
      reqBits     <= '0;
      tcBits      <= '0;
      ptrClrPulse <= 1'b0;
    end else begin
      cmdReg      <= cmdNext;
      maskReg     <= maskNext;
      reqBits     <= reqNext;
      tcBits      <= tcNext;
      ptrClrPulse <= strb.ptrClr | strb.masterRst;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_mode
      logic [MODE_W-1:0] modeReg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) modeReg <= '0;
        else if (strb.modeWr && (strb.chSel == CH_W'(g)))
          modeReg <= strb.data[BYTE_W-1:BYTE_W-MODE_W];
      end
      assign chMode[g] = modeFields_t'(modeReg);
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (strb.statusRd)    rdData = BYTE_W'({reqBits, tcBits});
    else if (strb.maskRd) rdData = BYTE_W'(maskReg);
  end

  assign eligVec    = ~maskReg & reqBits;
  assign ctlDisable = cmdReg[DIS_BIT];

  AST_MRESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.masterRst |=> (&maskReg) && (reqBits == '0) && (tcBits == '0) && (cmdReg == '0)); // R7
  AST_REQWR_CLEARS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    strb.reqWr |=> !tcBits[$past(strb.chSel)]); // R3
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.cmdWr && !strb.masterRst) |=> $stable(cmdReg)); // R2
  AST_PTR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ptrClr |=> ptrClrPulse); // R6
  AST_TC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tcHit[0] && !strb.masterRst && !(strb.reqWr && strb.chSel == '0)) |=> tcBits[0]); // R14
endmodule

// File: rtl/dmactl_arbiter.sv
module dmactl_arbiter
  import dmactl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] eligVec,
  input  logic              ctlDisable,
  input  modeFields_t       chMode [NUM_CH],
  output logic              grantValid,
  output logic [CH_W-1:0]   grantCh,
  output modeFields_t       grantMode
);
  logic            pickValid;
  logic [CH_W-1:0] pickCh;

  always_comb begin
    pickValid = 1'b0;
    pickCh    = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (eligVec[c]) begin
        pickValid = 1'b1;
        pickCh    = CH_W'(c);
      end
    end
    if (ctlDisable) begin
      pickValid = 1'b0;
      pickCh    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grantValid <= 1'b0;
      grantCh    <= '0;
      grantMode  <= '0;
    end else begin
      grantValid <= pickValid;
      grantCh    <= pickCh;
      grantMode  <= pickValid ? chMode[pickCh] : '0;
    end
  end

  AST_GRANT_WHEN_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    ((eligVec != '0) && !ctlDisable) |=> grantValid); // R11
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (eligVec == '0) |=> !grantValid); // R11
  AST_DISABLED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ctlDisable |=> !grantValid); // R12
  AST_CH0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (eligVec[0] && !ctlDisable) |=> (grantCh == '0)); // R11
endmodule

// File: rtl/dmactl_top.sv
module dmactl_top
  import dmactl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int WIDTH_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [3:0]        dreqHold,
  input  logic [3:0]        dreqRelease,
  input  logic [3:0]        tcHit,
  output logic              grantValid,
  output logic [1:0]        grantCh,
  output logic [1:0]        grantXferType,
  output logic              grantAutoInit,
  output logic              grantDecrement,
  output logic [1:0]        grantOpMode,
  output logic              ptrClear
);
  ctlStrobe_t        strb;
  logic [NUM_CH-1:0] eligVec;
  logic              ctlDisable;
  modeFields_t       chMode [NUM_CH];
  modeFields_t       grantMode;

  dmactl_decode #(.ADDR_W(ADDR_W), .WIDTH_SHIFT(WIDTH_SHIFT)) u_decode (
    .wrEn(wrEn), .rdEn(rdEn), .portAddr(portAddr), .wrData(wrData), .strb(strb)
  );

  dmactl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .dreqHold(dreqHold), .dreqRelease(dreqRelease), .tcHit(tcHit),
    .rdData(rdData), .eligVec(eligVec), .ctlDisable(ctlDisable),
    .chMode(chMode), .ptrClrPulse(ptrClear)
  );

  dmactl_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .eligVec(eligVec), .ctlDisable(ctlDisable),
    .chMode(chMode), .grantValid(grantValid), .grantCh(grantCh), .grantMode(grantMode)
  );

  assign grantXferType  = grantMode.xferType;
  assign grantAutoInit  = grantMode.autoInit;
  assign grantDecrement = grantMode.decrement;
  assign grantOpMode    = grantMode.opMode;
endmodule

// File: tb/dmactl_top_tb_top.sv
module dmactl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] portAddr = '0, wrData = '0;
  logic [7:0] rdData;
  logic [3:0] dreqHold = '0, dreqRelease = '0, tcHit = '0;
  logic       grantValid, grantAutoInit, grantDecrement, ptrClear;
  logic [1:0] grantCh, grantXferType, grantOpMode;

  int total = 0;
  int bad = 0;

  logic [7:0] mCmd;
  logic [3:0] mMask, mReq, mTc;
  logic [5:0] mMode [4];

  always #2 clk = ~clk;

  dmactl_top #(.ADDR_W(8), .WIDTH_SHIFT(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .portAddr(portAddr),
    .wrData(wrData), .rdData(rdData), .dreqHold(dreqHold), .dreqRelease(dreqRelease),
    .tcHit(tcHit), .grantValid(grantValid), .grantCh(grantCh),
    .grantXferType(grantXferType), .grantAutoInit(grantAutoInit),
    .grantDecrement(grantDecrement), .grantOpMode(grantOpMode), .ptrClear(ptrClear)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d,
                      input logic [3:0] h, input logic [3:0] rl, input logic [3:0] t, input string tag);
    int idx;
    logic [7:0] expRd;
    logic       gV;
    int         gCh;
    logic [5:0] gM;
    logic [8:0] expG, actG;
    wrEn = w; rdEn = r; portAddr = a; wrData = d;
    dreqHold = h; dreqRelease = rl; tcHit = t;
    idx = (int'(a) >> 1) & 15;
    #1;
    if (r) begin
      expRd = (idx == 0) ? {mReq, mTc} : (idx == 1) ? {4'b0, mMask} : 8'h00;
      chk(rdData === expRd, tag, "rdData", int'(rdData), int'(expRd));
    end
    @(posedge clk);
    gV = 1'b0; gCh = 0; gM = '0;
    if (!mCmd[2]) begin
      for (int c = 3; c >= 0; c--) begin
        if (!mMask[c] && mReq[c]) begin gV = 1'b1; gCh = c; end
      end
    end
    if (gV) gM = mMode[gCh];
    expG = {gV, 2'(gCh), gM[1:0], gM[2], gM[3], gM[5:4]};
    if (r && idx == 0) mTc = '0;
    mTc = mTc | t;
    mReq = (mReq | h) & ~rl;
    if (w) begin
      case (idx)
        0: if ((d & 8'hFB) == 8'h00) mCmd = d;
        1: begin mReq[d[1:0]] = d[2]; mTc[d[1:0]] = 1'b0; end
        2: mMask[d[1:0]] = d[2];
        3: mMode[d[1:0]] = d[7:2];
        5: begin mMask = 4'hF; mReq = '0; mTc = '0; mCmd = '0; end
        6: mMask = '0;
        7: mMask = d[3:0];
        default: ;
      endcase
    end
    #1;
    actG = {grantValid, grantCh, grantXferType, grantAutoInit, grantDecrement, grantOpMode};
    chk(actG === expG, tag, "grant", int'(actG), int'(expG));
    chk(ptrClear === (w && (idx == 4 || idx == 5)), tag, "ptrClear", int'(ptrClear),
        int'(w && (idx == 4 || idx == 5)));
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    tick(1'b1, 1'b0, a, d, 4'h0, 4'h0, 4'h0, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    tick(1'b0, 1'b1, a, 8'h00, 4'h0, 4'h0, 4'h0, tag);
  endtask
  task automatic idle(input string tag);
    tick(1'b0, 1'b0, 8'h00, 8'h00, 4'h0, 4'h0, 4'h0, tag);
  endtask
  task automatic ext(input logic [3:0] h, input logic [3:0] rl, input logic [3:0] t, input string tag);
    tick(1'b0, 1'b0, 8'h00, 8'h00, h, rl, t, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mCmd = '0; mMask = 4'hF; mReq = '0; mTc = '0;
    for (int i = 0; i < 4; i++) mMode[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    rd(8'h00, "R7");
    rd(8'h02, "R7");
    // R5 modes, R8 clear all masks
    wr(8'h06, 8'hB5, "R5");
    wr(8'h06, 8'h4B, "R5");
    wr(8'h07, 8'h62, "R5");
    wr(8'h0C, 8'h00, "R8");
    rd(8'h02, "R8");
    // R3 request ch1, R11 grant
    wr(8'h02, 8'h05, "R3");
    idle("R11");
    rd(8'h00, "R9");
    // R13 hold ch2, ch1 still wins
    ext(4'h4, 4'h0, 4'h0, "R13");
    idle("R11");
    wr(8'h02, 8'h01, "R3");
    idle("R11");
    // R4 single mask
    wr(8'h04, 8'h06, "R4");
    idle("R4");
    wr(8'h05, 8'h02, "R4");
    idle("R4");
    // R12 disable and R2 filtering
    wr(8'h00, 8'h04, "R12");
    idle("R12");
    wr(8'h00, 8'h14, "R2");
    idle("R2");
    wr(8'h00, 8'h00, "R12");
    idle("R12");
    wr(8'h00, 8'h84, "R2");
    idle("R2");
    wr(8'h00, 8'h01, "R2");
    idle("R2");
    // R14 and R9 tc flags
    ext(4'h0, 4'h0, 4'h8, "R14");
    rd(8'h00, "R14");
    rd(8'h00, "R9");
    ext(4'h0, 4'h0, 4'h2, "R14");
    tick(1'b0, 1'b1, 8'h00, 8'h00, 4'h0, 4'h0, 4'h1, "R9");
    rd(8'h00, "R9");
    // R3 request write clears tc
    ext(4'h0, 4'h0, 4'h8, "R14");
    wr(8'h02, 8'h03, "R3");
    rd(8'h00, "R3");
    // R13 release; hold+release collide
    ext(4'h9, 4'h0, 4'h0, "R13");
    idle("R13");
    ext(4'h1, 4'h1, 4'h0, "R13");
    idle("R13");
    tick(1'b1, 1'b0, 8'h02, 8'h04, 4'h0, 4'h1, 4'h0, "R13");
    rd(8'h00, "R13");
    // R6 pointer clear
    wr(8'h08, 8'h00, "R6");
    idle("R6");
    // R7 master reset keeps modes
    wr(8'h0A, 8'h00, "R7");
    rd(8'h00, "R7");
    rd(8'h02, "R7");
    wr(8'h0C, 8'h00, "R7");
    wr(8'h02, 8'h05, "R7");
    idle("R5");
    wr(8'h02, 8'h07, "R5");
    wr(8'h02, 8'h01, "R5");
    idle("R5");
    // R8 mask load
    wr(8'h0E, 8'h0A, "R8");
    rd(8'h02, "R8");
    idle("R8");
    // R1 ignored indices and alias address
    for (int k = 8; k < 16; k++) wr(8'(2 * k), 8'hFF, "R1");
    rd(8'h00, "R1");
    rd(8'h03, "R1");
    wr(8'h0D, 8'h00, "R1");
    rd(8'h02, "R1");
    // R10 other reads
    rd(8'h04, "R10");
    rd(8'h0E, "R10");
    rd(8'h1A, "R10");
    idle("R11");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule